// File: doc/BRIEF.md
# Chained Receive Status Queue

This block keeps the bookkeeping for receptions in a network controller that runs in command-chaining mode. The host issues enable-receive commands, and each one books one pending reception in a queue that is two entries deep. The receive engine, which is outside this block, signals the start of a packet with `rxStart`. It signals the end with `rxDone`, which carries a status word.

The first completed result is latched into a visible status register. This sets the receive-complete flag and raises the interrupt, and both stay put until the host issues a clear-receive-interrupt command. A second result that completes in the meantime is parked in a hidden slot. After the first result is cleared, the interrupt stays low for a fixed number of clock cycles. The parked result then moves into the visible register and the interrupt rises again.

A disable-receiver command withdraws the oldest booked reception that has not started yet. An interrupt-enable input gates only the interrupt line, never the receive-complete flag.

Top module: `rx_chain_status`

## Requirements
- R1: After reset, `rxCompl`, `rxIrq`, `rxActive` and `overflow` are 0, `pendCount` is 0 and `statusOut` is 0. Reset never sets `rxCompl`.
- R2: Each `cmdEnRx` pulse raises `pendCount` by one, up to 2. `rxStart` is accepted only when `pendCount` is nonzero and no reception is active, and it then drives `rxActive` to 1. At any other time `rxStart` has no effect.
- R3: An `rxDone` pulse during an active reception lowers `pendCount` by one and clears `rxActive`. If no result is held, it also copies `rxStatus` into `statusOut` and sets `rxCompl` on the next cycle. An `rxDone` pulse with no active reception is ignored.
- R4: Once set, `rxCompl` and `statusOut` do not change until a `cmdClrInt` pulse arrives.
- R5: `rxIrq` is high only while `rxCompl` is 1 and `rxIntEn` is 1. With `rxIntEn` at 0, `rxCompl` still sets.
- R6: A result that completes while another is visible is held. `statusOut` keeps showing the first result.
- R7: `cmdClrInt` with a result visible drops `rxCompl` and `rxIrq` for exactly GAP_CYC cycles when a result is held. The held status then appears on `statusOut`, and `rxCompl` and the interrupt reassert.
- R8: `cmdDisRx` removes one queued reception that has not started. When the only queued reception is already active, it has no effect.
- R9: Two `cmdDisRx` pulses cancel two queued, unstarted receptions and leave `pendCount` at 0.
- R10: `cmdEnRx` while `pendCount` is 2 is ignored and sets the sticky `overflow` output, which stays set until reset.
- R11: `cmdClrInt` while no result is visible has no effect on `rxCompl`, `rxIrq`, `statusOut` or `pendCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdEnRx | input | 1 | Enable-receive command pulse |
| cmdDisRx | input | 1 | Disable-receiver command pulse |
| cmdClrInt | input | 1 | Clear-receive-interrupt command pulse |
| rxIntEn | input | 1 | Receive interrupt enable (0 masks the interrupt only) |
| rxStart | input | 1 | Packet reception began |
| rxDone | input | 1 | Packet reception finished |
| rxStatus | input | STW | Status word of the finished packet |
| statusOut | output | STW | Visible receive status |
| rxCompl | output | 1 | Receive-complete flag |
| rxIrq | output | 1 | Receive interrupt |
| pendCount | output | 2 | Booked receptions, active one included |
| rxActive | output | 1 | A reception is under way |
| overflow | output | 1 | Sticky: command or result was dropped |

## Verification
The assertions assume that every command and receive input is a single-cycle pulse. They also assume that `rxDone` follows a matching `rxStart`, and that no two commands arrive in the same cycle. The bench drives each stimulus as a one-cycle pulse from a task and waits between tasks. It never overlaps commands with receive events, so the properties are checked only under those conditions.

// File: rtl/rx_chain_pkg.sv
package rx_chain_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadA;    // new result into visible slot
    logic loadB;    // new result into held slot
    logic promote;  // held slot moves to visible slot
    logic dropA;    // visible slot acknowledged
  } rxqStrobe_t;
endpackage

// File: rtl/rx_chain_ctrl.sv
module rx_chain_ctrl
  import rx_chain_pkg::*;
#(
  parameter int GAP_CYC = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdEnRx,
  input  logic       cmdDisRx,
  input  logic       cmdClrInt,
  input  logic       rxStart,
  input  logic       rxDone,
  input  logic       aValid,
  input  logic       bValid,
  output rxqStrobe_t strb,
  output logic [1:0] pendCount,
  output logic       rxActive,
  output logic       overflow
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  logic [1:0]    qCnt, qCntNxt;
  logic          busy, busyNxt;
  logic          ovf, ovfNxt;
  logic [GW-1:0] gapCnt;
  logic          gapBusy, doneOk, startOk, clrOk, dropNew;

  assign gapBusy = (gapCnt != '0);
  assign doneOk  = rxDone && busy;
  assign startOk = rxStart && !busy && (qCnt != 2'd0);
  assign clrOk   = cmdClrInt && aValid;

  always_comb begin
    strb.dropA   = clrOk;
    strb.promote = !aValid && !gapBusy && bValid;
    strb.loadA   = doneOk && !aValid && !gapBusy && !bValid;
    strb.loadB   = doneOk && !strb.loadA && (!bValid || strb.promote);
    dropNew      = doneOk && !strb.loadA && !strb.loadB;
  end

  always_comb begin
    qCntNxt = qCnt;
    busyNxt = busy;
    ovfNxt  = ovf || dropNew;
    if (doneOk) begin
      qCntNxt = qCntNxt - 2'd1;
      busyNxt = 1'b0;
    end
    if (startOk) busyNxt = 1'b1;
    if (cmdDisRx && (qCntNxt > {1'b0, busyNxt})) qCntNxt = qCntNxt - 2'd1;
    if (cmdEnRx) begin
      if (qCntNxt < 2'd2) qCntNxt = qCntNxt + 2'd1;
      else ovfNxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt   <= '0;
      busy   <= 1'b0;
      ovf    <= 1'b0;
      gapCnt <= '0;
    end else begin
      qCnt <= qCntNxt;
      busy <= busyNxt;
      ovf  <= ovfNxt;
      if (clrOk)        gapCnt <= GAP_LOAD;
      else if (gapBusy) gapCnt <= gapCnt - GW'(1);
    end
  end

  assign pendCount = qCnt;
  assign rxActive  = busy;
  assign overflow  = ovf;

  // R2: queue depth bounded, active entry always counted
  a_r2_depth: assert property (@(posedge clk) disable iff (!rstN) qCnt <= 2'd2);
  a_r2_busy_counted: assert property (@(posedge clk) disable iff (!rstN) busy |-> qCnt != 2'd0);
  // R10: overflow is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN) ovf |=> ovf);
  // R10: full queue ignores another enable
  a_r10_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnRx && qCnt == 2'd2 && !rxDone && !cmdDisRx) |=> (qCnt == 2'd2 && ovf));
  // R7: gap counter runs only after an acknowledgement
  a_r7_gap_loaded: assert property (@(posedge clk) disable iff (!rstN)
    clrOk |=> gapBusy || (GAP_CYC == 1));
endmodule

// File: rtl/rx_chain_dp.sv
module rx_chain_dp
  import rx_chain_pkg::*;
#(
  parameter int STW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  rxqStrobe_t     strb,
  input  logic [STW-1:0] rxStatus,
  output logic           aValid,
  output logic           bValid,
  output logic [STW-1:0] statusOut
);
  logic [STW-1:0] aData, bData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      bValid <= 1'b0;
      aData  <= '0;
      bData  <= '0;
    end else begin
      if (strb.dropA) aValid <= 1'b0;
      if (strb.promote) begin
        aValid <= 1'b1;
        aData  <= bData;
        bValid <= 1'b0;
      end
      if (strb.loadA) begin
        aValid <= 1'b1;
        aData  <= rxStatus;
      end
      if (strb.loadB) begin
        bValid <= 1'b1;
        bData  <= rxStatus;
      end
    end
  end

  assign statusOut = aData;

  // R4: visible result stays until acknowledged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && !strb.dropA) |=> (aValid && $stable(aData)));
  // R6: held result is not disturbed before promotion
  a_r6_held: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !strb.promote) |=> (bValid && $stable(bData)));
  // R3: a captured result becomes visible next cycle
  a_r3_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadA |=> aValid);
  a_r6_strobes_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadA && strb.promote));
endmodule

// File: rtl/rx_chain_status.sv
module rx_chain_status
  import rx_chain_pkg::*;
#(
  parameter int STW     = 8,
  parameter int GAP_CYC = 25
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdEnRx,
  input  logic           cmdDisRx,
  input  logic           cmdClrInt,
  input  logic           rxIntEn,
  input  logic           rxStart,
  input  logic           rxDone,
  input  logic [STW-1:0] rxStatus,
  output logic [STW-1:0] statusOut,
  output logic           rxCompl,
  output logic           rxIrq,
  output logic [1:0]     pendCount,
  output logic           rxActive,
  output logic           overflow
);
  rxqStrobe_t strb;
  logic aValid, bValid;

  rx_chain_ctrl #(.GAP_CYC(GAP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdEnRx(cmdEnRx), .cmdDisRx(cmdDisRx),
    .cmdClrInt(cmdClrInt), .rxStart(rxStart), .rxDone(rxDone),
    .aValid(aValid), .bValid(bValid), .strb(strb),
    .pendCount(pendCount), .rxActive(rxActive), .overflow(overflow)
  );

  rx_chain_dp #(.STW(STW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxStatus(rxStatus),
    .aValid(aValid), .bValid(bValid), .statusOut(statusOut)
  );

  assign rxCompl = aValid;
  assign rxIrq   = aValid && rxIntEn;

  // R7: acknowledgement drops the flag on the following cycle
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (cmdClrInt && rxCompl) |=> !rxCompl);
  // R11: clear with nothing visible leaves the flag low
  a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmdClrInt && !rxCompl && !rxDone && !bValid) |=> !rxCompl);
endmodule

// File: tb/sim_rx_chain_status.sv
module sim_rx_chain_status;
  localparam int STW = 8;
  localparam int GAP = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEnRx = 0, cmdDisRx = 0, cmdClrInt = 0, rxIntEn = 1, rxStart = 0, rxDone = 0;
  logic [STW-1:0] rxStatus = '0;
  logic [STW-1:0] statusOut;
  logic rxCompl, rxIrq, rxActive, overflow;
  logic [1:0] pendCount;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  logic [STW-1:0] expQ[$];
  logic prevTri = 1'b0;

  always #4 clk = ~clk;

  rx_chain_status #(.STW(STW), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rstN(rstN), .cmdEnRx(cmdEnRx), .cmdDisRx(cmdDisRx),
    .cmdClrInt(cmdClrInt), .rxIntEn(rxIntEn), .rxStart(rxStart), .rxDone(rxDone),
    .rxStatus(rxStatus), .statusOut(statusOut), .rxCompl(rxCompl), .rxIrq(rxIrq),
    .pendCount(pendCount), .rxActive(rxActive), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // monitor: each new visible result is compared with the scoreboard
  always @(negedge clk) begin
    if (rstN && rxCompl && !prevTri) begin
      if (expQ.size() == 0) check(0, "R3 unexpected result", statusOut, -1);
      else begin
        logic [STW-1:0] e;
        e = expQ.pop_front();
        check(statusOut == e, "R3/R7 result order", statusOut, e);
      end
    end
    prevTri = rxCompl;
  end

  task automatic doEn();  @(negedge clk) cmdEnRx = 1;   @(negedge clk) cmdEnRx = 0;   endtask
  task automatic doDis(); @(negedge clk) cmdDisRx = 1;  @(negedge clk) cmdDisRx = 0;  endtask
  task automatic doClr(); @(negedge clk) cmdClrInt = 1; @(negedge clk) cmdClrInt = 0; endtask
  task automatic doStart(); @(negedge clk) rxStart = 1; @(negedge clk) rxStart = 0; endtask
  task automatic doDone(input logic [STW-1:0] st, input bit expect_it);
    if (expect_it) expQ.push_back(st);
    @(negedge clk) begin rxDone = 1; rxStatus = st; end
    @(negedge clk) rxDone = 0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    idle(3);
    // R1: reset state
    check(rxCompl == 0 && rxIrq == 0 && rxActive == 0, "R1 flags", rxCompl, 0);
    check(pendCount == 0 && overflow == 0 && statusOut == 0, "R1 counts", pendCount, 0);
    rstN = 1;
    idle(2);
    check(rxCompl == 0, "R1 no flag after reset", rxCompl, 0);

    // R2: start with nothing booked is ignored
    doStart();
    check(rxActive == 0, "R2 start ignored", rxActive, 0);
    doEn();
    check(pendCount == 1, "R2 one booked", pendCount, 1);
    doEn();
    check(pendCount == 2, "R2 two booked", pendCount, 2);
    doStart();
    check(rxActive == 1, "R2 active", rxActive, 1);

    // R3, R5
    doDone(8'hA5, 1);
    check(rxCompl == 1 && statusOut == 8'hA5, "R3 latched", statusOut, 8'hA5);
    check(pendCount == 1 && rxActive == 0, "R3 popped", pendCount, 1);
    check(rxIrq == 1, "R5 irq enabled", rxIrq, 1);

    // R4
    idle(10);
    check(rxCompl == 1 && statusOut == 8'hA5, "R4 holds", statusOut, 8'hA5);

    // R6: second result parked
    doStart();
    doDone(8'h3C, 1);
    check(statusOut == 8'hA5 && rxCompl == 1, "R6 first still shown", statusOut, 8'hA5);
    check(pendCount == 0, "R6 queue empty", pendCount, 0);

    // R7: gap then reassert
    doClr();
    begin
      int lows = 0;
      while (!rxCompl && lows < 200) begin
        check(rxIrq == 0, "R7 irq low in gap", rxIrq, 0);
        lows++;
        @(negedge clk);
      end
      check(lows == GAP, "R7 gap length", lows, GAP);
    end
    check(statusOut == 8'h3C && rxIrq == 1, "R7 held result", statusOut, 8'h3C);

    // R11: clear with nothing visible
    doClr();
    idle(GAP + 2);
    doClr();
    check(rxCompl == 0 && rxIrq == 0, "R11 no flag", rxCompl, 0);
    check(statusOut == 8'h3C && pendCount == 0, "R11 status kept", statusOut, 8'h3C);

    // R5: mask gates interrupt only
    rxIntEn = 0;
    doEn(); doStart();
    doDone(8'h5A, 1);
    check(rxCompl == 1 && rxIrq == 0, "R5 masked", rxIrq, 0);
    rxIntEn = 1;
    #1;
    check(rxIrq == 1, "R5 unmasked", rxIrq, 1);
    doClr();
    idle(GAP + 2);

    // R8
    doEn(); doStart(); doDis();
    check(pendCount == 1 && rxActive == 1, "R8 active not cancelled", pendCount, 1);
    doEn();
    check(pendCount == 2, "R8 two booked", pendCount, 2);
    doDis();
    check(pendCount == 1 && rxActive == 1, "R8 unstarted cancelled", pendCount, 1);
    doDone(8'h77, 1);
    check(pendCount == 0 && statusOut == 8'h77, "R8 done", statusOut, 8'h77);
    doClr();
    idle(GAP + 2);

    // R9
    doEn(); doEn(); doDis(); doDis();
    check(pendCount == 0, "R9 both cancelled", pendCount, 0);
    doStart();
    check(rxActive == 0, "R9 nothing to start", rxActive, 0);
    doDone(8'h99, 0);
    check(rxCompl == 0, "R3 stray done ignored", rxCompl, 0);

    // R10
    check(overflow == 0, "R10 no overflow yet", overflow, 0);
    doEn(); doEn(); doEn();
    check(pendCount == 2 && overflow == 1, "R10 third ignored", pendCount, 2);
    doDis(); doDis();
    check(overflow == 1, "R10 sticky", overflow, 1);

    idle(4);
    check(expQ.size() == 0, "R3 all results seen", expQ.size(), 0);
    finished = 1;
    summary();
  end
endmodule